// File: doc/BRIEF.md
# Tagged Many-to-Few Request Switch

This block merges `NUM_OUT × FAN` request channels onto `NUM_OUT` output channels. The inputs fall into groups of `FAN` consecutive channels, one group for each output. Within a group, a round-robin arbiter picks one pending request per cycle. The winner's local slot number is appended below its tag, so the forwarded tag is `TAG_W + log2(FAN)` bits wide.

Responses come back on the output side. The block decodes the low `log2(FAN)` tag bits to find the slot and shifts those bits out. It then delivers the response to the matching input of the same group. No table is kept. When `FAN` is 1, every input maps straight to one output, and tags, handshakes and responses pass through unchanged.

Requests are combinational from input to output, with a valid/ready handshake. Each arbiter's cursor is the only state. Responses carry no backpressure: each output returns at most one response per cycle, and it is steered combinationally.

Top module: `tagged_req_switch`

## Requirements
- R1: With `FAN` = 1, input k drives output k unchanged (valid, address, write, tag), `in_req_ready[k]` equals `out_req_ready[k]`, and a response on output k appears on input k with the same tag and data.
- R2: Input j belongs to output `j / FAN` and has local slot `j % FAN`. It only ever competes for, and is forwarded to, that output.
- R3: `out_req_valid[o]` is high exactly when at least one input of group o has a pending request. The output address and write bit are those of the granted slot.
- R4: A forwarded request's tag is `{input tag, slot}`, with the slot in the low `log2(FAN)` bits.
- R5: Each group's slots are examined in the order (cursor + r) mod FAN for r = 0..FAN−1, and the first pending one wins. `in_req_ready` is high only for that winner, and only when the output is ready. After reset, every cursor is 0.
- R6: After an accepted grant, the cursor moves to the slot after the winner, wrapping to 0 after FAN−1. Without an accepted grant, it holds.
- R7: While `out_req_ready[o]` is low, no input of group o sees ready and the group's cursor does not move. The output still presents the current winner.
- R8: A response on output o with tag T goes to input `o×FAN + T[log2(FAN)-1:0]`. It carries tag `T >> log2(FAN)` and unchanged data, and no other input of the group sees a response.
- R9: Responses on different outputs are steered independently in the same cycle. With no response valid, no input sees one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_req_valid | input | NUM_IN | Request valid per input |
| in_req_ready | output | NUM_IN | Request accepted per input |
| in_req_addr | input | NUM_IN×ADDR_W | Request address per input |
| in_req_write | input | NUM_IN | Request is a write |
| in_req_tag | input | NUM_IN×TAG_W | Request tag per input |
| in_rsp_valid | output | NUM_IN | Response valid per input |
| in_rsp_tag | output | NUM_IN×TAG_W | Restored response tag |
| in_rsp_data | output | NUM_IN×DATA_W | Response data |
| out_req_valid | output | NUM_OUT | Forwarded request valid |
| out_req_ready | input | NUM_OUT | Downstream accepts request |
| out_req_addr | output | NUM_OUT×ADDR_W | Forwarded address |
| out_req_write | output | NUM_OUT | Forwarded write bit |
| out_req_tag | output | NUM_OUT×OTAG_W | Tag extended with slot |
| out_rsp_valid | input | NUM_OUT | Response valid per output |
| out_rsp_tag | input | NUM_OUT×OTAG_W | Extended response tag |
| out_rsp_data | input | NUM_OUT×DATA_W | Response data |

## Verification
The embedded properties check, on every cycle, these rules:
- At most one grant per group, and a grant only to a pending slot (R5).
- No grant and a frozen cursor while stalled (R6, R7).
- The cursor steps past the winner after an accepted grant (R6).
- Output valid tracks group occupancy (R3).
- A valid response reaches exactly one slot (R8).
- Tags pass untouched in the direct variant (R1).

The order of grants only shows over sequences of cycles, so the bench's scenarios check it. They cover:
- rotation from reset;
- a stall followed by resumption at the same slot;
- wrap-around past the last slot;
- two groups arbitrating independently.

The bench also checks the exact extended tag values, and the restored tags and data of simultaneous responses on both outputs.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  // number of tag bits spent on the slot index for a group of `fan` inputs
  function automatic int sel_width(input int fan);
    return (fan > 1) ? $clog2(fan) : 0;
  endfunction
endpackage

// File: rtl/tsw_rr_arb.sv
module tsw_rr_arb #(
  parameter int FAN = 4,
  localparam int CW = (FAN > 1) ? $clog2(FAN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FAN-1:0] pend,
  input  logic           ready,
  output logic [FAN-1:0] grant,
  output logic [CW-1:0]  win,
  output logic           any
);
  logic [CW-1:0] cursor;
  logic          accept;

  // rotating search starting at the cursor; returns {found, index}
  function automatic logic [CW:0] rr_pick(input logic [FAN-1:0] p, input logic [CW-1:0] cur);
    logic [CW-1:0] idx;
    logic          found;
    logic [CW-1:0] sel;
    found = 1'b0;
    sel   = '0;
    for (int r = 0; r < FAN; r++) begin
      idx = CW'((int'(cur) + r) % FAN);
      if (!found && p[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
    return {found, sel};
  endfunction

  function automatic logic [CW-1:0] step(input logic [CW-1:0] w);
    return (int'(w) == FAN - 1) ? '0 : CW'(int'(w) + 1);
  endfunction

  always_comb begin
    {any, win} = rr_pick(pend, cursor);
    accept     = any && ready;
    grant      = '0;
    if (accept) grant[win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cursor <= '0;
    else if (accept) cursor <= step(win);
  end

  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r5_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
  a_r6_cursor_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (cursor == step($past(win))));
  a_r6_cursor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> $stable(cursor));
  a_r7_no_grant_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (grant == '0));
endmodule

// File: rtl/tsw_rsp_steer.sv
module tsw_rsp_steer #(
  parameter int FAN    = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int SW     = tsw_pkg::sel_width(FAN),
  localparam int OTAG_W = TAG_W + SW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rsp_valid,
  input  logic [OTAG_W-1:0]       rsp_tag,
  input  logic [DATA_W-1:0]       rsp_data,
  output logic [FAN-1:0]          slot_valid,
  output logic [FAN*TAG_W-1:0]    slot_tag,
  output logic [FAN*DATA_W-1:0]   slot_data
);
  logic [SW-1:0]    slot;
  logic [TAG_W-1:0] orig_tag;

  assign slot     = rsp_tag[SW-1:0];
  assign orig_tag = rsp_tag[OTAG_W-1:SW];

  for (genvar k = 0; k < FAN; k++) begin : g_slot
    assign slot_valid[k]                   = rsp_valid && (slot == SW'(k));
    assign slot_tag[k*TAG_W +: TAG_W]      = orig_tag;
    assign slot_data[k*DATA_W +: DATA_W]   = rsp_data;
  end

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot(slot_valid));
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (slot_valid == '0));
endmodule

// File: rtl/tagged_req_switch.sv
module tagged_req_switch #(
  parameter int NUM_OUT = 2,
  parameter int FAN     = 4,
  parameter int ADDR_W  = 16,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 8,
  localparam int NUM_IN = NUM_OUT * FAN,
  localparam int SW     = tsw_pkg::sel_width(FAN),
  localparam int OTAG_W = TAG_W + SW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IN-1:0]           in_req_valid,
  output logic [NUM_IN-1:0]           in_req_ready,
  input  logic [NUM_IN*ADDR_W-1:0]    in_req_addr,
  input  logic [NUM_IN-1:0]           in_req_write,
  input  logic [NUM_IN*TAG_W-1:0]     in_req_tag,
  output logic [NUM_IN-1:0]           in_rsp_valid,
  output logic [NUM_IN*TAG_W-1:0]     in_rsp_tag,
  output logic [NUM_IN*DATA_W-1:0]    in_rsp_data,
  output logic [NUM_OUT-1:0]          out_req_valid,
  input  logic [NUM_OUT-1:0]          out_req_ready,
  output logic [NUM_OUT*ADDR_W-1:0]   out_req_addr,
  output logic [NUM_OUT-1:0]          out_req_write,
  output logic [NUM_OUT*OTAG_W-1:0]   out_req_tag,
  input  logic [NUM_OUT-1:0]          out_rsp_valid,
  input  logic [NUM_OUT*OTAG_W-1:0]   out_rsp_tag,
  input  logic [NUM_OUT*DATA_W-1:0]   out_rsp_data
);
  if (FAN == 1) begin : g_direct
    assign out_req_valid = in_req_valid;
    assign out_req_addr  = in_req_addr;
    assign out_req_write = in_req_write;
    assign out_req_tag   = in_req_tag;
    assign in_req_ready  = out_req_ready;
    assign in_rsp_valid  = out_rsp_valid;
    assign in_rsp_tag    = out_rsp_tag;
    assign in_rsp_data   = out_rsp_data;

    a_r1_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req_tag == in_req_tag) && (in_rsp_tag == out_rsp_tag));
  end else begin : g_switch
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      localparam int BASE = o * FAN;
      logic [FAN-1:0]    grant;
      logic [SW-1:0]     win;
      logic              any;
      logic [ADDR_W-1:0] w_addr;
      logic [TAG_W-1:0]  w_tag;
      logic              w_write;

      tsw_rr_arb #(.FAN(FAN)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (in_req_valid[BASE +: FAN]),
        .ready (out_req_ready[o]),
        .grant (grant),
        .win   (win),
        .any   (any)
      );

      assign w_addr  = in_req_addr[(BASE + int'(win))*ADDR_W +: ADDR_W];
      assign w_tag   = in_req_tag[(BASE + int'(win))*TAG_W +: TAG_W];
      assign w_write = in_req_write[BASE + int'(win)];

      assign in_req_ready[BASE +: FAN]          = grant;
      assign out_req_valid[o]                   = any;
      assign out_req_addr[o*ADDR_W +: ADDR_W]   = w_addr;
      assign out_req_write[o]                   = w_write;
      assign out_req_tag[o*OTAG_W +: OTAG_W]    = {w_tag, win};

      tsw_rsp_steer #(.FAN(FAN), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_valid  (out_rsp_valid[o]),
        .rsp_tag    (out_rsp_tag[o*OTAG_W +: OTAG_W]),
        .rsp_data   (out_rsp_data[o*DATA_W +: DATA_W]),
        .slot_valid (in_rsp_valid[BASE +: FAN]),
        .slot_tag   (in_rsp_tag[BASE*TAG_W +: FAN*TAG_W]),
        .slot_data  (in_rsp_data[BASE*DATA_W +: FAN*DATA_W])
      );

      a_r3_valid_tracks_group: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid[o] == (|in_req_valid[BASE +: FAN]));
      a_r7_stall_blocks_group: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req_ready[o] |-> (in_req_ready[BASE +: FAN] == '0));
    end
  end
endmodule

// File: tb/test_tagged_req_switch.sv
module test_tagged_req_switch;
  localparam int CLK_P = 10;
  localparam int NO = 2, R = 4, NI = NO * R, AW = 16, TW = 4, DW = 8, SW = 2, OTW = TW + SW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [NI-1:0] in_req_valid, in_req_ready, in_req_write, in_rsp_valid;
  logic [NI*AW-1:0] in_req_addr;
  logic [NI*TW-1:0] in_req_tag, in_rsp_tag;
  logic [NI*DW-1:0] in_rsp_data;
  logic [NO-1:0] out_req_valid, out_req_ready, out_req_write, out_rsp_valid;
  logic [NO*AW-1:0] out_req_addr;
  logic [NO*OTW-1:0] out_req_tag, out_rsp_tag;
  logic [NO*DW-1:0] out_rsp_data;

  tagged_req_switch #(.NUM_OUT(NO), .FAN(R), .ADDR_W(AW), .TAG_W(TW), .DATA_W(DW)) i_tagged_req_switch (
    .clk(clk), .rst_n(rst_n),
    .in_req_valid(in_req_valid), .in_req_ready(in_req_ready), .in_req_addr(in_req_addr),
    .in_req_write(in_req_write), .in_req_tag(in_req_tag),
    .in_rsp_valid(in_rsp_valid), .in_rsp_tag(in_rsp_tag), .in_rsp_data(in_rsp_data),
    .out_req_valid(out_req_valid), .out_req_ready(out_req_ready), .out_req_addr(out_req_addr),
    .out_req_write(out_req_write), .out_req_tag(out_req_tag),
    .out_rsp_valid(out_rsp_valid), .out_rsp_tag(out_rsp_tag), .out_rsp_data(out_rsp_data));

  // direct (FAN = 1) variant
  logic [1:0] p_iv, p_ir, p_iw, p_rv, p_ov, p_or, p_ow, p_orv;
  logic [2*AW-1:0] p_ia, p_oa;
  logic [2*TW-1:0] p_it, p_rt, p_ot, p_ort;
  logic [2*DW-1:0] p_rd, p_ord;

  tagged_req_switch #(.NUM_OUT(2), .FAN(1), .ADDR_W(AW), .TAG_W(TW), .DATA_W(DW)) i_tagged_req_switch_pt (
    .clk(clk), .rst_n(rst_n),
    .in_req_valid(p_iv), .in_req_ready(p_ir), .in_req_addr(p_ia), .in_req_write(p_iw), .in_req_tag(p_it),
    .in_rsp_valid(p_rv), .in_rsp_tag(p_rt), .in_rsp_data(p_rd),
    .out_req_valid(p_ov), .out_req_ready(p_or), .out_req_addr(p_oa), .out_req_write(p_ow), .out_req_tag(p_ot),
    .out_rsp_valid(p_orv), .out_rsp_tag(p_ort), .out_rsp_data(p_ord));

  typedef struct { string req; int kind; int idx; logic [63:0] exp; } item_t;
  item_t q[$];
  event ev_mon;
  int checks = 0, failures = 0, tbase = 0;
  int cur [NO];
  bit done = 0;

  function automatic logic [63:0] actual(int kind, int idx);
    case (kind)
      0: return 64'(out_req_valid[idx]);
      1: return 64'(out_req_tag[idx*OTW +: OTW]);
      2: return 64'(out_req_addr[idx*AW +: AW]);
      3: return 64'(in_req_ready);
      4: return 64'(out_req_write[idx]);
      5: return 64'(in_rsp_valid);
      6: return 64'(in_rsp_tag[idx*TW +: TW]);
      7: return 64'(in_rsp_data[idx*DW +: DW]);
      8: return 64'({p_ov, p_ot, p_oa, p_ow, p_ir});
      9: return 64'({p_rv, p_rt, p_rd});
      default: return 64'hDEAD;
    endcase
  endfunction

  // monitor: pops expected items and compares with the design
  always @(ev_mon) begin
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] a;
      it = q.pop_front();
      a = actual(it.kind, it.idx);
      checks++;
      if (a !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, a, it.exp);
      end
    end
  end

  function automatic logic [TW-1:0] tag_of(int j); return TW'((j * 5 + tbase) & 15); endfunction
  function automatic logic [AW-1:0] addr_of(int j); return AW'(16'h0100 * j + tbase); endfunction

  task automatic put(int j, bit v);
    in_req_valid[j] = v;
    in_req_addr[j*AW +: AW] = addr_of(j);
    in_req_write[j] = j[0];
    in_req_tag[j*TW +: TW] = tag_of(j);
  endtask

  task automatic push(string rq, int kind, int idx, logic [63:0] e);
    item_t it;
    it.req = rq; it.kind = kind; it.idx = idx; it.exp = e;
    q.push_back(it);
  endtask

  task automatic sample();
    #2; -> ev_mon; #1;
  endtask

  // driver for the request side: model from the requirements, then compare
  task automatic req_cycle(string rq);
    logic [NI-1:0] rdy;
    int win [NO];
    rdy = '0;
    for (int o = 0; o < NO; o++) begin
      win[o] = -1;
      for (int r = 0; r < R; r++) begin
        int s;
        s = (cur[o] + r) % R;
        if (win[o] < 0 && in_req_valid[o*R + s]) win[o] = s;
      end
      push(rq, 0, o, 64'(win[o] >= 0));
      if (win[o] >= 0) begin
        int j;
        j = o * R + win[o];
        push(rq, 1, o, 64'({tag_of(j), SW'(win[o])}));
        push(rq, 2, o, 64'(addr_of(j)));
        push(rq, 4, o, 64'(j[0]));
        if (out_req_ready[o]) rdy[j] = 1'b1;
      end
    end
    push(rq, 3, 0, 64'(rdy));
    sample();
    for (int o = 0; o < NO; o++)
      if (win[o] >= 0 && out_req_ready[o]) cur[o] = (win[o] + 1) % R;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_req_valid = '0; in_req_addr = '0; in_req_write = '0; in_req_tag = '0;
    out_req_ready = '0; out_rsp_valid = '0; out_rsp_tag = '0; out_rsp_data = '0;
    p_iv = '0; p_ia = '0; p_iw = '0; p_it = '0; p_or = '0; p_orv = '0; p_ort = '0; p_ord = '0;
    for (int o = 0; o < NO; o++) cur[o] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state: idle outputs, no responses, no ready
    push("R3 reset idle", 0, 0, 0); push("R3 reset idle", 0, 1, 0);
    push("R9 reset no rsp", 5, 0, 0); push("R5 reset no ready", 3, 0, 0);
    sample();

    // R5 R6 R2 R4: full group 0 rotates 0,1,2,3,0 from a reset cursor of 0
    @(negedge clk);
    out_req_ready = 2'b11;
    for (int j = 0; j < R; j++) put(j, 1);
    for (int n = 0; n < 5; n++) begin
      req_cycle("R5 R6 rotation group0");
      @(negedge clk);
    end

    // R7: stall group 0 for two cycles, cursor must hold (winner stays slot 1)
    out_req_ready = 2'b10;
    req_cycle("R7 stalled cycle1");
    @(negedge clk);
    req_cycle("R7 stalled cycle2");
    @(negedge clk);
    out_req_ready = 2'b11;
    req_cycle("R7 resume same winner");
    @(negedge clk);

    // R5 wrap: cursor at 2, only slots 0 and 1 pending
    tbase = 7;
    put(2, 0); put(3, 0); put(0, 1); put(1, 1);
    req_cycle("R5 wrap to slot0");
    @(negedge clk);
    req_cycle("R5 wrap then slot1");
    @(negedge clk);

    // R2 R3: two groups arbitrate independently
    tbase = 3;
    put(0, 0); put(1, 0); put(2, 1); put(5, 1); put(7, 1);
    for (int n = 0; n < 3; n++) begin
      req_cycle("R2 R3 independent groups");
      @(negedge clk);
    end
    for (int j = 0; j < NI; j++) put(j, 0);
    req_cycle("R3 idle again");

    // R8 R9: responses on both outputs in one cycle
    @(negedge clk);
    out_rsp_valid = 2'b11;
    out_rsp_tag   = {6'b0011_11, 6'b1010_10};
    out_rsp_data  = {8'hE1, 8'h5C};
    push("R9 dual rsp valids", 5, 0, 64'h84);
    push("R8 rsp tag slot2", 6, 2, 64'hA); push("R8 rsp data slot2", 7, 2, 64'h5C);
    push("R8 rsp tag in7", 6, 7, 64'h3);  push("R8 rsp data in7", 7, 7, 64'hE1);
    sample();
    @(negedge clk);
    out_rsp_valid = 2'b01;
    out_rsp_tag   = {6'b0, 6'b1111_00};
    out_rsp_data  = {8'h00, 8'h77};
    push("R8 rsp slot0 only", 5, 0, 64'h01);
    push("R8 rsp tag slot0", 6, 0, 64'hF); push("R8 rsp data slot0", 7, 0, 64'h77);
    sample();
    @(negedge clk);
    out_rsp_valid = 2'b00;
    push("R9 no rsp", 5, 0, 64'h0);
    sample();

    // R1: direct variant passes everything unchanged
    @(negedge clk);
    p_iv = 2'b01; p_ia = {16'h2222, 16'h1111}; p_iw = 2'b01; p_it = {4'h4, 4'h9}; p_or = 2'b10;
    push("R1 direct req", 8, 0, 64'({2'b01, 8'h49, 32'h2222_1111, 2'b01, 2'b10}));
    p_orv = 2'b10; p_ort = {4'hC, 4'h0}; p_ord = {8'h3A, 8'h00};
    push("R1 direct rsp", 9, 0, 64'({2'b10, 8'hC0, 16'h3A00}));
    sample();
    @(negedge clk);
    p_or = 2'b01;
    push("R1 direct ready", 8, 0, 64'({2'b01, 8'h49, 32'h2222_1111, 2'b01, 2'b01}));
    sample();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule